// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits behind the host bus of a boot-sector flash array. It watches byte-wide write cycles and recognises the six-write erase command sequences. It then tells the erase engine which sectors to erase and when to begin. The write strobe arrives asynchronously. It is synchronised inside the block, and a write counts at the rising edge of the strobe. The address and data bus are sampled when that edge is detected.

A chip-erase sequence starts erasure at once, with every sector selected. A sector-erase sequence opens an acceptance window. While the window is open, further sector commands can be queued, and each one pushes the window end out again. When the window runs out, erasure begins. A foreign write during the window throws the whole queue away. Once erasure is running, only the suspend code produces a response. The erase engine ends the operation with a completion pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read array), `sector_sel` is all zero, and `erase_start`, `window_closed` and `suspend_req` are 0. The mode encoding is 0 = read array, 1 = erase pending (window open), 2 = erasing.
- R2: From read mode, the six writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 start a chip erase. The addresses are word offsets, and the sector field is ignored. The result is one `erase_start` pulse, `mode` = 2, `sector_sel` all ones and `window_closed` = 1.
- R3: The same five-write prefix followed by data 30 starts a sector erase. The top SEC_W address bits of that sixth write pick the sector, and bit i of `sector_sel` stands for sector i. `mode` becomes 1 and `window_closed` stays 0.
- R4: The window closes exactly WINDOW_CYCLES = CLK_MHZ*WINDOW_US clock cycles after the cycle in which the last sector command was accepted. On closing, `erase_start` pulses once, and in the same cycle `mode` becomes 2 and `window_closed` becomes 1.
- R5: While `mode` = 1, a single write of data 30 sets the bit of the sector in its address, in any order and for any number of sectors, and restarts the full window. This also applies when the write is accepted in the very cycle the window would have expired.
- R6: While `mode` = 1, a write whose data is neither 30 nor B0 returns `mode` to 0 and clears `sector_sel`. No `erase_start` follows.
- R7: While `mode` = 1, a write of data B0 leaves `mode` and `sector_sel` unchanged.
- R8: While `mode` = 2, a write of B0 gives one `suspend_req` pulse. Every other write, including 30 and a write that lands one cycle after the window closed, leaves `mode` and `sector_sel` unchanged.
- R9: A write that does not match the expected step of the unlock sequence returns the decoder to the first step with no change to any output. A later complete sequence is recognised normally.
- R10: `erase_done` high while `mode` = 2 returns `mode` to 0, clears `sector_sel` and clears `window_closed`.
- R11: A write takes effect only after `we_n` returns high. However long `we_n` is held low, it has no effect before that rise. Address and data must stay valid for at least 3 cycles after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| we_n | input | 1 | Asynchronous active-low write strobe |
| addr | input | ADDR_W | Word address, sector index in the top SEC_W bits |
| data | input | 8 | Command data byte |
| erase_done | input | 1 | Completion pulse from the erase engine |
| mode | output | 2 | 0 read array, 1 erase pending, 2 erasing |
| sector_sel | output | NUM_SECTORS | Bitmap of sectors selected for erase |
| erase_start | output | 1 | One-cycle pulse that launches the erase engine |
| window_closed | output | 1 | 1 once the acceptance window has expired and erasing runs |
| suspend_req | output | 1 | One-cycle pulse on a suspend code during erasing |

## Verification
The window timer's expiry and the acceptance of a new sector command can land in the same clock cycle. The bench provokes this by raising the strobe of a second sector command exactly WINDOW_CYCLES cycles after the first one. The bench expects the command to win: the window restarts, and the later start pulse must carry both sectors. A second run moves the same write one cycle later. There the expiry comes first, the late command must be ignored, and the scoreboard expects a start carrying only the first sector.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [1:0] {
      MODE_READ  = 2'd0,
      MODE_PEND  = 2'd1,
      MODE_ERASE = 2'd2
   } fcd_mode_e;

   localparam int          UNLOCK_OFS_W = 11;
   localparam logic [10:0] UNLOCK_ADR_A = 11'h555;
   localparam logic [10:0] UNLOCK_ADR_B = 11'h2AA;

   localparam logic [7:0] CODE_KEY_A = 8'hAA;
   localparam logic [7:0] CODE_KEY_B = 8'h55;
   localparam logic [7:0] CODE_SETUP = 8'h80;
   localparam logic [7:0] CODE_CHIP  = 8'h10;
   localparam logic [7:0] CODE_SECT  = 8'h30;
   localparam logic [7:0] CODE_SUSP  = 8'hB0;

endpackage

// File: rtl/fcd_strobe_sync.sv
module fcd_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic rise_evt
);
   localparam int LAST = STAGES;

   logic [LAST:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '1;
      else        shreg <= {shreg[LAST-1:0], strobe_n};
   end

   assign rise_evt = shreg[LAST-1] & ~shreg[LAST];

endmodule

// File: rtl/fcd_unlock_seq.sv
module fcd_unlock_seq
   import fcd_pkg::*;
#(
   parameter int OFS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_evt,
   input  logic             enable,
   input  logic [OFS_W-1:0] offset,
   input  logic [7:0]       code,
   output logic             chip_hit,
   output logic             sect_hit
);
   localparam logic [OFS_W-1:0] ADR_A = OFS_W'(UNLOCK_ADR_A);
   localparam logic [OFS_W-1:0] ADR_B = OFS_W'(UNLOCK_ADR_B);
   localparam logic [2:0]       FINAL = 3'd5;

   logic [2:0] step_q;
   logic       step_ok;
   logic       at_a, at_b;

   assign at_a = (offset == ADR_A);
   assign at_b = (offset == ADR_B);

   always_comb begin
      case (step_q)
         3'd0, 3'd3: step_ok = at_a && (code == CODE_KEY_A);
         3'd1, 3'd4: step_ok = at_b && (code == CODE_KEY_B);
         3'd2:       step_ok = at_a && (code == CODE_SETUP);
         default:    step_ok = 1'b0;
      endcase
   end

   assign chip_hit = wr_evt && enable && (step_q == FINAL) && at_a && (code == CODE_CHIP);
   assign sect_hit = wr_evt && enable && (step_q == FINAL) && (code == CODE_SECT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  step_q <= '0;
      else if (!enable)            step_q <= '0;
      else if (wr_evt) begin
         if (step_q == FINAL)      step_q <= '0;
         else if (step_ok)         step_q <= step_q + 3'd1;
         else                      step_q <= '0;
      end
   end

endmodule

// File: rtl/fcd_window_timer.sv
module fcd_window_timer #(
   parameter int CYCLES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic cancel,
   output logic running,
   output logic expire
);
   localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   assign running = run_q;
   assign expire  = run_q && (cnt_q == '0) && !load && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (cancel) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load) begin
         run_q <= 1'b1;
         cnt_q <= RELOAD;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/fcd_sector_map.sv
module fcd_sector_map #(
   parameter int NUM_SECTORS = 8,
   parameter int SEC_W       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic [SEC_W-1:0]       set_idx,
   input  logic                   set_all,
   input  logic                   clear,
   output logic [NUM_SECTORS-1:0] sel
);
   for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
      localparam logic [SEC_W-1:0] MY_IDX = SEC_W'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              sel[i] <= 1'b0;
         else if (clear)                          sel[i] <= 1'b0;
         else if (set_all)                        sel[i] <= 1'b1;
         else if (set_en && (set_idx == MY_IDX))  sel[i] <= 1'b1;
      end
   end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int NUM_SECTORS = 8,
   parameter int CLK_MHZ     = 100,
   parameter int WINDOW_US   = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [7:0]             data,
   input  logic                   erase_done,
   output logic [1:0]             mode,
   output logic [NUM_SECTORS-1:0] sector_sel,
   output logic                   erase_start,
   output logic                   window_closed,
   output logic                   suspend_req
);
   localparam int SEC_W         = $clog2(NUM_SECTORS);
   localparam int OFS_W         = ADDR_W - SEC_W;
   localparam int WINDOW_CYCLES = CLK_MHZ * WINDOW_US;

   if (NUM_SECTORS < 2 || (1 << SEC_W) != NUM_SECTORS) begin : g_bad_sectors
      $error("NUM_SECTORS must be a power of two, at least 2");
   end
   if (OFS_W < UNLOCK_OFS_W) begin : g_bad_addr
      $error("ADDR_W too small for unlock offsets plus sector field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WINDOW_CYCLES < 2) begin : g_bad_window
      $error("acceptance window must span at least 2 cycles");
   end

   logic             wr_evt;
   logic [OFS_W-1:0] offset;
   logic [SEC_W-1:0] sec_idx;
   logic             chip_hit, sect_hit;
   logic             pend_sect, pend_abort, erase_susp, finish;
   logic             tmr_load, tmr_run, tmr_expire;
   logic             map_set, map_clear;
   fcd_mode_e        mode_q, mode_d;
   logic             start_q, closed_q, susp_q;

   assign offset  = addr[OFS_W-1:0];
   assign sec_idx = addr[ADDR_W-1 -: SEC_W];

   fcd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (we_n),
      .rise_evt (wr_evt)
   );

   fcd_unlock_seq #(.OFS_W(OFS_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_evt   (wr_evt),
      .enable   (mode_q == MODE_READ),
      .offset   (offset),
      .code     (data),
      .chip_hit (chip_hit),
      .sect_hit (sect_hit)
   );

   assign pend_sect  = (mode_q == MODE_PEND) && wr_evt && (data == CODE_SECT);
   assign pend_abort = (mode_q == MODE_PEND) && wr_evt
                       && (data != CODE_SECT) && (data != CODE_SUSP);
   assign erase_susp = (mode_q == MODE_ERASE) && wr_evt && (data == CODE_SUSP);
   assign finish     = (mode_q == MODE_ERASE) && erase_done;

   assign tmr_load  = sect_hit || pend_sect;
   assign map_set   = sect_hit || pend_sect;
   assign map_clear = pend_abort || finish;

   fcd_window_timer #(.CYCLES(WINDOW_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .cancel  (pend_abort),
      .running (tmr_run),
      .expire  (tmr_expire)
   );

   fcd_sector_map #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (map_set),
      .set_idx (sec_idx),
      .set_all (chip_hit),
      .clear   (map_clear),
      .sel     (sector_sel)
   );

   always_comb begin
      mode_d = mode_q;
      case (mode_q)
         MODE_READ: begin
            if (chip_hit)      mode_d = MODE_ERASE;
            else if (sect_hit) mode_d = MODE_PEND;
         end
         MODE_PEND: begin
            if (pend_abort)                  mode_d = MODE_READ;
            else if (tmr_expire || !tmr_run) mode_d = tmr_expire ? MODE_ERASE : MODE_PEND;
         end
         MODE_ERASE: begin
            if (finish) mode_d = MODE_READ;
         end
         default: mode_d = MODE_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_READ;
         start_q  <= 1'b0;
         closed_q <= 1'b0;
         susp_q   <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         start_q <= chip_hit || ((mode_q == MODE_PEND) && tmr_expire);
         susp_q  <= erase_susp;
         if (finish)
            closed_q <= 1'b0;
         else if (chip_hit || ((mode_q == MODE_PEND) && tmr_expire))
            closed_q <= 1'b1;
      end
   end

   assign mode          = mode_q;
   assign erase_start   = start_q;
   assign window_closed = closed_q;
   assign suspend_req   = susp_q;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
   import fcd_pkg::*;
#(
   parameter int NUM_SECTORS = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   erase_done,
   input logic [1:0]             mode,
   input logic [NUM_SECTORS-1:0] sector_sel,
   input logic                   erase_start,
   input logic                   window_closed,
   input logic                   suspend_req
);
   p_read_no_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_READ) |-> (sector_sel == '0));

   p_pend_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PEND) |-> (sector_sel != '0) && !window_closed);

   p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |=> !erase_start);

   p_start_enters_erase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> (mode == MODE_ERASE) && window_closed);

   p_flag_tracks_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      window_closed == (mode == MODE_ERASE));

   p_pend_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PEND) |=> (mode != MODE_PEND)
                              || ((sector_sel & $past(sector_sel)) == $past(sector_sel)));

   p_erase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_ERASE && !erase_done) |=> (mode == MODE_ERASE) && $stable(sector_sel));

   p_susp_in_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_req |-> $past(mode) == MODE_ERASE);

   p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);

endmodule

bind flash_cmd_decoder fcd_checker #(.NUM_SECTORS(NUM_SECTORS)) u_fcd_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .erase_done    (erase_done),
   .mode          (mode),
   .sector_sel    (sector_sel),
   .erase_start   (erase_start),
   .window_closed (window_closed),
   .suspend_req   (suspend_req)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 14;
   localparam int NSEC       = 8;
   localparam int WIN        = 50;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        data = '0;
   logic              erase_done = 1'b0;
   logic [1:0]        mode;
   logic [NSEC-1:0]   sector_sel;
   logic              erase_start;
   logic              window_closed;
   logic              suspend_req;

   int vectors = 0;
   int fails   = 0;
   int susp_cnt = 0;
   logic [NSEC-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_decoder #(
      .ADDR_W(ADDR_W), .NUM_SECTORS(NSEC), .CLK_MHZ(1), .WINDOW_US(WIN), .SYNC_STAGES(2)
   ) u_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .data(data),
      .erase_done(erase_done), .mode(mode), .sector_sel(sector_sel),
      .erase_start(erase_start), .window_closed(window_closed), .suspend_req(suspend_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: every start pulse is compared against the queued expectation
   always @(negedge clk) begin
      if (rst_n && erase_start) begin
         if (exp_q.size() == 0) begin
            vectors++; fails++;
            $display("FAIL R4: actual start with sel %0h expected no start", sector_sel);
         end else begin
            logic [NSEC-1:0] e;
            e = exp_q.pop_front();
            check("R4 start bitmap", 32'(sector_sel), 32'(e));
         end
      end
      if (rst_n && suspend_req) susp_cnt++;
   end

   function automatic logic [ADDR_W-1:0] sa(input int s);
      return {3'(s), 11'h123};
   endfunction

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; data = d; we_n = 1'b0;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic unlock6(input logic [ADDR_W-1:0] a6, input logic [7:0] d6);
      bus_write(14'h555, 8'hAA);
      bus_write(14'h2AA, 8'h55);
      bus_write(14'h555, 8'h80);
      bus_write(14'h555, 8'hAA);
      bus_write(14'h2AA, 8'h55);
      bus_write(a6, d6);
   endtask

   task automatic finish_erase();
      @(negedge clk); erase_done = 1'b1;
      @(negedge clk); erase_done = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      vectors++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
   end

   initial begin
      int s0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 mode", 32'(mode), 0);
      check("R1 sel", 32'(sector_sel), 0);
      check("R1 flags", {29'd0, erase_start, window_closed, suspend_req}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 chip erase
      exp_q.push_back('1);
      unlock6(14'h555, 8'h10);
      check("R2 mode", 32'(mode), 2);
      check("R2 sel", 32'(sector_sel), 32'hFF);
      check("R2 closed", 32'(window_closed), 1);
      // R8 other writes ignored, suspend honoured
      bus_write(sa(3), 8'h30);
      check("R8 mode after 30", 32'(mode), 2);
      check("R8 sel after 30", 32'(sector_sel), 32'hFF);
      s0 = susp_cnt;
      bus_write(sa(0), 8'hB0);
      check("R8 suspend pulse", 32'(susp_cnt - s0), 1);
      // R10 completion
      finish_erase();
      check("R10 mode", 32'(mode), 0);
      check("R10 sel", 32'(sector_sel), 0);
      check("R10 closed", 32'(window_closed), 0);

      // R3 / R4 sector erase and exact window length
      exp_q.push_back(8'h20);
      unlock6(sa(5), 8'h30);
      check("R3 mode", 32'(mode), 1);
      check("R3 sel", 32'(sector_sel), 32'h20);
      check("R3 closed", 32'(window_closed), 0);
      repeat (WIN - 3) @(negedge clk);
      check("R4 still open", 32'(mode), 1);
      repeat (2) @(negedge clk);
      check("R4 erasing", 32'(mode), 2);
      check("R4 closed", 32'(window_closed), 1);
      finish_erase();

      // R5 additional sectors restart the window
      exp_q.push_back(8'h42);
      unlock6(sa(6), 8'h30);
      repeat (30) @(negedge clk);
      bus_write(sa(1), 8'h30);
      check("R5 sel", 32'(sector_sel), 32'h42);
      repeat (WIN - 3) @(negedge clk);
      check("R5 window restarted", 32'(mode), 1);
      repeat (2) @(negedge clk);
      check("R5 erasing", 32'(mode), 2);
      finish_erase();

      // R6 foreign write aborts
      unlock6(sa(2), 8'h30);
      bus_write(sa(0), 8'hF0);
      check("R6 mode", 32'(mode), 0);
      check("R6 sel", 32'(sector_sel), 0);
      repeat (WIN + 10) @(negedge clk);
      check("R6 no start", 32'(mode), 0);

      // R7 suspend code inside window
      exp_q.push_back(8'h10);
      unlock6(sa(4), 8'h30);
      bus_write(sa(1), 8'hB0);
      check("R7 mode", 32'(mode), 1);
      check("R7 sel", 32'(sector_sel), 32'h10);
      repeat (WIN + 5) @(negedge clk);
      check("R7 later erasing", 32'(mode), 2);
      finish_erase();

      // R9 broken unlock
      bus_write(14'h555, 8'hAA);
      bus_write(14'h2AA, 8'h55);
      bus_write(14'h555, 8'h80);
      bus_write(14'h555, 8'hAA);
      bus_write(14'h2AA, 8'h12);
      check("R9 mode after break", 32'(mode), 0);
      bus_write(sa(3), 8'h30);
      check("R9 no carry", 32'(mode), 0);
      check("R9 sel", 32'(sector_sel), 0);
      exp_q.push_back(8'h08);
      unlock6(sa(3), 8'h30);
      check("R9 full sequence ok", 32'(mode), 1);
      repeat (WIN + 2) @(negedge clk);
      finish_erase();

      // R5 command lands in the expiry cycle: command wins
      exp_q.push_back(8'h81);
      unlock6(sa(0), 8'h30);
      repeat (WIN - 7) @(negedge clk);
      bus_write(sa(7), 8'h30);
      check("R5 coincident open", 32'(mode), 1);
      check("R5 coincident sel", 32'(sector_sel), 32'h81);
      repeat (WIN - 3) @(negedge clk);
      check("R5 coincident restarted", 32'(mode), 1);
      repeat (2) @(negedge clk);
      check("R5 coincident erasing", 32'(mode), 2);
      finish_erase();

      // R8 command one cycle after expiry is ignored
      exp_q.push_back(8'h04);
      unlock6(sa(2), 8'h30);
      repeat (WIN - 6) @(negedge clk);
      bus_write(sa(6), 8'h30);
      check("R8 late mode", 32'(mode), 2);
      check("R8 late sel", 32'(sector_sel), 32'h04);
      finish_erase();

      // R11 nothing happens while strobe held low
      exp_q.push_back(8'h02);
      unlock6(sa(1), 8'h30);
      @(negedge clk);
      addr = sa(0); data = 8'hF0; we_n = 1'b0;
      repeat (20) @(negedge clk);
      check("R11 held low", 32'(mode), 1);
      exp_q.delete();
      we_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R11 after rise", 32'(mode), 0);
      check("R11 sel", 32'(sector_sel), 0);

      repeat (5) @(negedge clk);
      check("R4 scoreboard drained", 32'(exp_q.size()), 0);
      summary();
      $finish;
   end

endmodule